// File: doc/BRIEF.md
# Unaligned Sync Marker Hunter

This block watches a parallel data bus that carries one new word per clock and finds a fixed synchronisation marker anywhere in the bit stream. The marker is one zero followed by W-1 ones, where W is the bus width (32 by default). The marker can start at any bit of a word, so it can be split across two words. The block therefore keeps the last accepted word and joins it with the word now on the bus. All W candidate start positions in the older word are compared in parallel within one clock.

Each accepted beat reports at most one marker. The report is a one-cycle pulse plus the start offset inside the older word. After a marker is reported, the search carries on from the first bit after that marker, and that bit may lie inside the word that closed the marker. Clock-domain crossing and everything that consumes the pulse sit outside this block.

Top module: `sync_hunt`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its outputs and its search state. After reset, `match` is 0 and `match_offset` is 0 until a marker is found.
- R2: The bit stream is read MSB first within each word, and earlier words come before later ones. The marker is the 32-bit value 0x7FFFFFFF in stream order: a single zero, then W-1 ones.
- R3: A marker that starts at any offset 0..W-1 of a word is detected, including markers split across two words. `match_offset` gives the start position inside the older word, where 0 is the MSB.
- R4: A marker that starts in accepted word n is reported in the clock cycle after accepted word n+1 is sampled. This holds even when the marker lies wholly within word n.
- R5: A beat with `in_valid` low changes no search state and gives `match` 0 on the next cycle. A marker split around such gaps is still found.
- R6: After a marker, the search resumes at the bit right after it. Back-to-back markers are each reported, and so is a marker that starts later in the word where the last one ended. No reported offset is below the resume point.
- R7: Each marker gives exactly one `match` pulse, and a beat never reports more than one marker.
- R8: The first valid word after reset only fills the history. An all-ones first word never produces a match.
- R9: `match_offset` is 0 in every cycle in which `match` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` for this clock |
| in_data | input | W | Bus word, MSB is the earliest bit |
| match | output | 1 | One-cycle pulse per marker found |
| match_offset | output | $clog2(W) | Marker start offset in the older word |

## Verification
The hardest cases to reach are those where the resume point matters. In one, a marker starts within the same word where the previous marker ended. In the other, markers run back to back at an offset other than zero, so that every window joins the tail of one marker with the head of the next. The directed tasks build these bit streams directly: markers are placed at chosen stream positions in a wide vector, which is then cut into words. The bench also sweeps every start offset, and it breaks a split marker with invalid gaps. A bit-serial model in the bench predicts every report, and a mixed random stream is checked against that model.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  // Stream value of the marker bit at position idx (0 = first bit in time).
  function automatic logic marker_bit(input int unsigned idx);
    return (idx != 0);
  endfunction

  // Window offset where the next search may start after this beat.
  // A marker at offset off in the older word ends at off-1 of the newer
  // word, so the newer word (next beat's older word) resumes at off.
  function automatic int unsigned resume_point(input logic found,
                                               input int unsigned off);
    return found ? off : 0;
  endfunction

endpackage

// File: rtl/sh_window.sv
module sh_window #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  output logic [2*W-1:0] window,
  output logic           primed,
  output logic           search_en
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (in_valid) begin
      prev_q   <= in_data;
      primed_q <= 1'b1;
    end
  end

  assign window    = {prev_q, in_data};
  assign primed    = primed_q;
  assign search_en = in_valid && primed_q;
endmodule

// File: rtl/sh_cand.sv
module sh_cand
  import sync_hunt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] window,
  output logic [W-1:0]   hit
);
  localparam int HI = 2*W - 1;

  function automatic logic [W-1:0] marker_word();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[W-1-i] = marker_bit(i);
    return m;
  endfunction

  localparam logic [W-1:0] MARKER = marker_word();

  for (genvar k = 0; k < W; k++) begin : g_off
    logic [W-1:0] cand;
    assign cand   = window[HI-k -: W];
    assign hit[k] = (cand == MARKER);
  end
endmodule

// File: rtl/sh_pick.sv
module sh_pick #(
  parameter int W  = 32,
  parameter int OW = $clog2(W)
) (
  input  logic [W-1:0]  hit,
  input  logic [OW-1:0] ptr,
  output logic          found,
  output logic [OW-1:0] off
);
  logic [W-1:0] eligible;

  always_comb begin
    for (int k = 0; k < W; k++) eligible[k] = hit[k] && (k >= int'(ptr));
  end

  always_comb begin
    found = 1'b0;
    off   = '0;
    for (int k = W-1; k >= 0; k--) begin
      if (eligible[k]) begin
        found = 1'b1;
        off   = OW'(k);
      end
    end
  end
endmodule

// File: rtl/sync_hunt.sv
module sync_hunt
  import sync_hunt_pkg::*;
#(
  parameter int W  = 32,
  parameter int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          match,
  output logic [OW-1:0] match_offset
);
  logic [2*W-1:0] window;
  logic           primed_q;
  logic           search_en;
  logic [W-1:0]   hit;
  logic [OW-1:0]  ptr_q;
  logic           found;
  logic [OW-1:0]  found_off;
  logic           report;
  logic           match_q;
  logic [OW-1:0]  off_q;

  sh_window #(.W(W)) u_window (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .window   (window),
    .primed   (primed_q),
    .search_en(search_en)
  );

  sh_cand #(.W(W)) u_cand (
    .window(window),
    .hit   (hit)
  );

  sh_pick #(.W(W), .OW(OW)) u_pick (
    .hit  (hit),
    .ptr  (ptr_q),
    .found(found),
    .off  (found_off)
  );

  assign report = search_en && found;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      off_q   <= '0;
      ptr_q   <= '0;
    end else begin
      match_q <= report;
      off_q   <= report ? found_off : '0;
      if (search_en) ptr_q <= OW'(resume_point(found, int'(found_off)));
    end
  end

  assign match        = match_q;
  assign match_offset = off_q;
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk #(
  parameter int OW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          primed_q,
  input logic [OW-1:0] ptr_q,
  input logic          match,
  input logic [OW-1:0] match_offset
);
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!match && ptr_q == '0));

  p_gap_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !match);

  p_resume_order_r6: assert property (@(posedge clk) disable iff (rst)
    match |-> (match_offset >= $past(ptr_q)));

  p_needs_full_window_r4: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(in_valid && primed_q));

  p_first_word_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !primed_q) |-> !match);

  p_offset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !match |-> (match_offset == '0));
endmodule

bind sync_hunt sync_hunt_chk #(.OW(OW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .primed_q    (primed_q),
  .ptr_q       (ptr_q),
  .match       (match),
  .match_offset(match_offset)
);

// File: tb/sync_hunt_tb.sv
module sync_hunt_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        match;
  logic [4:0]  match_offset;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // bit-serial reference model
  logic [31:0] sr;
  int nbits, next_ok, wcount, hitcount;
  bit exp_hit [0:4095];
  int exp_off [0:4095];
  logic last_m;
  int   last_o;

  always #2 clk = ~clk;

  sync_hunt u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .match(match), .match_offset(match_offset)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, got=%0d exp=<100000 cycles", cycles);
      summary();
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic model_clear();
    sr = '0; nbits = 0; next_ok = 0; wcount = 0;
    for (int i = 0; i < 4096; i++) begin exp_hit[i] = 0; exp_off[i] = 0; end
  endtask

  // R2: MSB first, marker is 0 followed by 31 ones
  task automatic model_feed(input logic [31:0] w);
    for (int b = 31; b >= 0; b--) begin
      sr = {sr[30:0], w[b]};
      nbits++;
      if (nbits >= 32) begin
        int st;
        st = nbits - 32;
        if (st >= next_ok && sr == 32'h7FFF_FFFF) begin
          exp_hit[st/32] = 1;
          exp_off[st/32] = st % 32;
          next_ok = st + 32;
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 match in reset", match, 0);
    check("R1 offset in reset", match_offset, 0);
    @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  task automatic beat(input logic [31:0] w, input logic v, input string tag);
    logic em; int eo; int n;
    @(negedge clk);
    in_data = w; in_valid = v;
    @(posedge clk); #1;
    em = 0; eo = 0;
    if (v) begin
      model_feed(w);
      n = wcount; wcount++;
      if (n >= 1 && exp_hit[n-1]) begin em = 1; eo = exp_off[n-1]; end
    end
    last_m = match; last_o = match_offset;
    if (match) hitcount++;
    check({tag, " match"}, match, em);
    check({tag, " offset R9"}, match_offset, eo);
  endtask

  task automatic send_stream(input logic [255:0] s, input int nw, input string tag);
    for (int i = 0; i < nw; i++) beat(s[255-32*i -: 32], 1'b1, tag);
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0;
  endtask

  // R8: all-ones first word never matches; R1 quiet after reset
  task automatic t_startup();
    do_reset();
    beat(32'h0, 1'b0, "R1 idle after reset");
    beat(32'hFFFF_FFFF, 1'b1, "R8 first word");
    check("R8 no match on first ones word", last_m, 0);
    beat(32'hFFFF_FFFF, 1'b1, "R8 second word");
    check("R8 no match on ones stream", last_m, 0);
    do_reset();
    beat(32'h7FFF_FFFF, 1'b1, "R4 aligned word");
    check("R4 not reported before next word", last_m, 0);
    beat(32'h1234_5678, 1'b1, "R4 next word");
    check("R4 offset0 reported one word later", last_m, 1);
    check("R3 offset0 value", last_o, 0);
    idle();
  endtask

  // R3: every start offset, including split markers
  task automatic t_every_offset();
    logic [255:0] s;
    do_reset();
    for (int off = 0; off < 32; off++) begin
      s = {8{$urandom}};
      s[255-32-off -: 32] = 32'h7FFF_FFFF;
      send_stream(s, 2, "R3 lead");
      beat(s[255-64 -: 32], 1'b1, "R3 close");
      check($sformatf("R3 hit at offset %0d", off), last_m, 1);
      check($sformatf("R3 offset value %0d", off), last_o, off);
    end
    idle();
  endtask

  // R6/R7: back-to-back markers, one pulse each
  task automatic t_back_to_back(input int off);
    logic [255:0] s;
    do_reset();
    s = '0;
    for (int j = 0; j < 3; j++) s[255-off-32*j -: 32] = 32'h7FFF_FFFF;
    hitcount = 0;
    send_stream(s, 5, "R6 back-to-back");
    check($sformatf("R7 one pulse per marker off=%0d", off), hitcount, 3);
    idle();
  endtask

  // R6: next marker starts later inside the word where the last ended
  task automatic t_same_word_resume();
    logic [255:0] s;
    do_reset();
    s = '0;
    s[255-3 -: 32]  = 32'h7FFF_FFFF;
    s[255-35 -: 17] = '1;
    s[255-52 -: 32] = 32'h7FFF_FFFF;
    send_stream(s, 2, "R6 first");
    check("R6 first marker", last_o, 3);
    beat(s[255-64 -: 32], 1'b1, "R6 second");
    check("R6 resume in same word hit", last_m, 1);
    check("R6 resume in same word offset", last_o, 20);
    idle();
  endtask

  // R5: gaps inside a split marker
  task automatic t_gaps();
    logic [255:0] s;
    do_reset();
    s = '0;
    s[255-10 -: 32] = 32'h7FFF_FFFF;
    beat(s[255 -: 32], 1'b1, "R5 head");
    for (int g = 0; g < 3; g++) begin
      beat(32'h0000_0000, 1'b0, "R5 gap");
      check("R5 no match on gap", last_m, 0);
    end
    beat(s[223 -: 32], 1'b1, "R5 tail");
    check("R5 split marker across gap", last_m, 1);
    check("R5 split marker offset", last_o, 10);
    idle();
  endtask

  // R2/R3/R4: mixed random stream against the model
  task automatic t_random();
    logic [31:0] w;
    logic v;
    do_reset();
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0: w = 32'hFFFF_FFFF;
        1: w = $urandom;
        2: w = ~(32'h1 << ($urandom % 32));
        default: w = 32'h7FFF_FFFF >> ($urandom % 32);
      endcase
      v = ($urandom % 5) != 0;
      beat(w, v, "R2 random stream");
    end
    idle();
  endtask

  initial begin
    void'($urandom(7));
    t_startup();
    t_every_offset();
    t_back_to_back(0);
    t_back_to_back(13);
    t_back_to_back(31);
    t_same_word_resume();
    t_gaps();
    t_random();
    summary();
  end
endmodule